// File: doc/BRIEF.md
# DTMF Digit Steering and Latch

This block sits behind a tone-pair detector. Each cycle it receives a raw "tone present" level and a 4-bit keypad position. It decides when that indication counts as a real key press and when the following silence counts as a real gap between keys. Both decisions use guard durations counted in clock cycles, and each duration is programmed on its own. When a press is accepted, the block converts the keypad position to the standard 4-bit digit code and latches it onto an output bus that can be tri-stated.

There are two steering outputs. An early flag mirrors the raw detect level at once. A qualified flag (data valid) rises when a tone has lasted long enough and falls when a gap has lasted long enough. An inhibit input blocks the four extended keys, and a power-down input holds the qualification logic idle. The inputs have no valid/ready handshake and cannot be held back: the detector's level is sampled every cycle. The latched code stays valid for as long as the qualified flag is high and keeps its value afterwards, so a reader has no back-pressure to manage.

Top module: `dtmf_steer`

## Requirements
- R1: The keypad position `key_pos` is row*4+column, with rows {1,2,3,A}, {4,5,6,B}, {7,8,9,C}, {*,0,#,D}. The latched code is 0001–1001 for digits 1–9, 1010 for 0, 1011 for *, 1100 for #, 1101 for A, 1110 for B, 1111 for C and 0000 for D.
- R2: While `out_en` is low, all four bits of `digit_o` are high impedance. While it is high, `digit_o` shows the latched code.
- R3: While `inhibit` is high, a tone on an extended key (column 3, keys A–D) keeps `early_o` low, never raises `valid_o`, and leaves the latched code unchanged.
- R4: While `inhibit` is high, the keys 0–9, * and # are qualified and encoded exactly as they are with `inhibit` low.
- R5: `early_o` equals `tone_det` in the same cycle, with no register in the path, except where R3 or R11 forces it low.
- R6: `valid_o` rises at the Nth consecutive clock edge at which `early_o` is high, where N = `on_guard` (a value of 0 acts as 1). A low cycle before that point restarts the count.
- R7: `valid_o` falls at the Mth consecutive clock edge at which `early_o` is low, where M = `off_guard` (a value of 0 acts as 1). A high cycle before that point restarts the count.
- R8: The code is loaded only at the edge where `valid_o` rises, from `key_pos` at that edge. Later changes of `key_pos` while `valid_o` is high do not alter it.
- R9: After reset, `valid_o` is low and the latched code is 0000.
- R10: A guard value is captured at the first edge of a count. Changing `on_guard` or `off_guard` during a count does not alter that count's length.
- R11: While `pwr_dn` is high, `early_o` and `valid_o` are low and the guard counts are cleared, but the latched code is kept. After release, a new full count is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down hold |
| tone_det | input | 1 | Raw tone-present level from the detector |
| key_pos | input | 4 | Keypad position row*4+column |
| inhibit | input | 1 | Block the extended keys A–D |
| out_en | input | 1 | Drive the code bus (low gives high impedance) |
| on_guard | input | 16 | Tone-present guard length in cycles |
| off_guard | input | 16 | Tone-absent guard length in cycles |
| early_o | output | 1 | Early steering flag |
| valid_o | output | 1 | Qualified (delayed) steering flag |
| digit_o | output | 4 | Latched digit code, tri-stated |

## Verification
Two of the block's functions can act in the same cycle: power-down and the completion of the tone-present count. The bench raises `pwr_dn` in exactly the cycle before the edge that would finish an accepted press. It expects `valid_o` to stay low, the latched code to keep its earlier value, and the next full count to start only after `pwr_dn` drops. A second overlap is checked as well: a one-cycle reversal of the tone during either guard window must push the transition back by a complete guard length.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  localparam int KEY_W = 4;
  typedef logic [KEY_W-1:0] key_code_t;

  // Column 3 of the keypad carries the extended keys
  function automatic logic is_ext_key(input logic [KEY_W-1:0] pos);
    return pos[1:0] == 2'd3;
  endfunction

  function automatic key_code_t pos_to_code(input logic [KEY_W-1:0] pos);
    logic [1:0] row;
    logic [1:0] col;
    key_code_t  res;
    row = pos[3:2];
    col = pos[1:0];
    if (col == 2'd3) begin
      res = (row == 2'd3) ? 4'd0 : key_code_t'(4'd13 + {2'b00, row});
    end else if (row != 2'd3) begin
      res = key_code_t'({2'b00, row} * 4'd3 + {2'b00, col} + 4'd1);
    end else begin
      case (col)
        2'd0:    res = 4'd11;
        2'd1:    res = 4'd10;
        default: res = 4'd12;
      endcase
    end
    return res;
  endfunction
endpackage

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_steer_pkg::*;
(
  input  logic [KEY_W-1:0] pos_i,
  input  logic             inhibit_i,
  output key_code_t        code_o,
  output logic             blocked_o
);
  always_comb begin
    code_o    = pos_to_code(pos_i);
    blocked_o = inhibit_i & is_ext_key(pos_i);
  end
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] on_lim_i,
  input  logic [CNT_W-1:0] off_lim_i,
  output logic             state_o,
  output logic             rise_o
);
  localparam int EXT_W = CNT_W + 1;

  logic             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             opposite;
  logic [CNT_W-1:0] lim_eff;
  logic [EXT_W-1:0] cnt_nxt;
  logic             reached;

  always_comb begin
    opposite = state_q ? ~lvl_i : lvl_i;
    lim_eff  = (cnt_q == '0) ? (state_q ? off_lim_i : on_lim_i) : lim_q;
    cnt_nxt  = {1'b0, cnt_q} + EXT_W'(1);
    reached  = cnt_nxt >= {1'b0, lim_eff};
    rise_o   = ~hold_i & ~state_q & opposite & reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else if (hold_i) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!opposite) begin
      cnt_q <= '0;
    end else if (reached) begin
      state_q <= ~state_q;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
      lim_q <= lim_eff;
    end
  end

  assign state_o = state_q;

  p_rise_needs_tone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> $past(lvl_i));
  p_fall_needs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q) |-> (!$past(lvl_i) || $past(hold_i)));
  p_hold_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !state_q);
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_dn,
  input  logic               tone_det,
  input  logic [KEY_W-1:0]   key_pos,
  input  logic               inhibit,
  input  logic               out_en,
  input  logic [GUARD_W-1:0] on_guard,
  input  logic [GUARD_W-1:0] off_guard,
  output logic               early_o,
  output logic               valid_o,
  output logic [KEY_W-1:0]   digit_o
);
  key_code_t enc_code;
  logic      ext_blocked;
  logic      load_code;
  key_code_t code_q;

  dtmf_key_encoder u_enc (
    .pos_i     (key_pos),
    .inhibit_i (inhibit),
    .code_o    (enc_code),
    .blocked_o (ext_blocked)
  );

  assign early_o = tone_det & ~ext_blocked & ~pwr_dn;

  dtmf_guard_timer #(.CNT_W(GUARD_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (pwr_dn),
    .lvl_i     (early_o),
    .on_lim_i  (on_guard),
    .off_lim_i (off_guard),
    .state_o   (valid_o),
    .rise_o    (load_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (load_code) code_q <= enc_code;
  end

  assign digit_o = out_en ? code_q : {KEY_W{1'bz}};

  p_code_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $rose(valid_o));
  p_inh_no_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) && $past(inhibit)) |-> (code_q inside {[4'd1:4'd12]}));
endmodule

// File: tb/dtmf_steer_tb_top.sv
module dtmf_steer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_dn = 1'b0, tone_det = 1'b0, inhibit = 1'b0, out_en = 1'b1;
  logic [3:0]  key_pos = '0;
  logic [15:0] on_guard = 16'd2, off_guard = 16'd2;
  logic        early_o, valid_o;
  wire  [3:0]  digit_o;
  int          n_chk = 0, n_err = 0;
  logic [3:0]  last_code = 4'd0;
  bit          done = 0;

  always #4 clk = ~clk;

  dtmf_steer dut_i (.clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tone_det(tone_det),
    .key_pos(key_pos), .inhibit(inhibit), .out_en(out_en), .on_guard(on_guard),
    .off_guard(off_guard), .early_o(early_o), .valid_o(valid_o), .digit_o(digit_o));

  function automatic logic [3:0] exp_code(input int p);
    case (p)
      0: return 4'd1;  1: return 4'd2;  2: return 4'd3;  3: return 4'd13;
      4: return 4'd4;  5: return 4'd5;  6: return 4'd6;  7: return 4'd14;
      8: return 4'd7;  9: return 4'd8;  10: return 4'd9; 11: return 4'd15;
      12: return 4'd11; 13: return 4'd10; 14: return 4'd12; default: return 4'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full press and release with guard lengths g_on, g_off (both >= 2)
  task automatic press(input string req, input int p, input int g_on, input int g_off);
    key_pos = 4'(p); on_guard = 16'(g_on); off_guard = 16'(g_off); tone_det = 1'b1;
    #1 check({req, " R5 early"}, {3'b0, early_o}, 4'd1);
    cyc(g_on - 1);
    check({req, " R6 before"}, {3'b0, valid_o}, 4'd0);
    cyc(1);
    check({req, " R6 rise"}, {3'b0, valid_o}, 4'd1);
    last_code = exp_code(p);
    check({req, " R1 code"}, digit_o, last_code);
    tone_det = 1'b0;
    #1 check({req, " R5 early low"}, {3'b0, early_o}, 4'd0);
    cyc(g_off - 1);
    check({req, " R7 before"}, {3'b0, valid_o}, 4'd1);
    cyc(1);
    check({req, " R7 fall"}, {3'b0, valid_o}, 4'd0);
  endtask

  task automatic t_reset();
    check("R9 valid", {3'b0, valid_o}, 4'd0);
    check("R9 code", digit_o, 4'd0);
    check("R9 early", {3'b0, early_o}, 4'd0);
  endtask

  task automatic t_all_keys();
    for (int p = 0; p < 16; p++) press("R1", p, 2, 2);
  endtask

  task automatic t_on_glitch();
    key_pos = 4'd5; on_guard = 16'd5; tone_det = 1'b1;
    cyc(3); tone_det = 1'b0; cyc(1); tone_det = 1'b1;
    cyc(4); check("R6 glitch restart", {3'b0, valid_o}, 4'd0);
    cyc(1); check("R6 after restart", {3'b0, valid_o}, 4'd1);
    last_code = 4'd5;
    off_guard = 16'd4; tone_det = 1'b0;
    cyc(2); tone_det = 1'b1; cyc(1); tone_det = 1'b0;
    cyc(3); check("R7 glitch restart", {3'b0, valid_o}, 4'd1);
    cyc(1); check("R7 after restart", {3'b0, valid_o}, 4'd0);
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1; key_pos = 4'd7; on_guard = 16'd2; tone_det = 1'b1;
    #1 check("R3 early blocked", {3'b0, early_o}, 4'd0);
    cyc(6);
    check("R3 no valid", {3'b0, valid_o}, 4'd0);
    check("R3 code kept", digit_o, last_code);
    tone_det = 1'b0; cyc(2);
    press("R4 digit under inhibit", 14, 3, 2);
    inhibit = 1'b0;
  endtask

  task automatic t_hold_and_oe();
    key_pos = 4'd9; on_guard = 16'd2; tone_det = 1'b1;
    cyc(2); key_pos = 4'd0; cyc(3);
    check("R8 hold", digit_o, 4'd8);
    last_code = 4'd8;
    out_en = 1'b0; #1 check("R2 hiz", digit_o, 4'bzzzz);
    out_en = 1'b1; #1 check("R2 drive", digit_o, 4'd8);
    off_guard = 16'd2; tone_det = 1'b0; cyc(2);
  endtask

  task automatic t_sample();
    key_pos = 4'd1; on_guard = 16'd6; tone_det = 1'b1;
    cyc(1); on_guard = 16'd1; cyc(4);
    check("R10 limit kept", {3'b0, valid_o}, 4'd0);
    cyc(1); check("R10 rise", {3'b0, valid_o}, 4'd1);
    last_code = 4'd2;
    off_guard = 16'd0; tone_det = 1'b0; cyc(1);
    check("R7 zero guard", {3'b0, valid_o}, 4'd0);
  endtask

  task automatic t_pwrdn();
    key_pos = 4'd13; on_guard = 16'd3; tone_det = 1'b1;
    cyc(2); pwr_dn = 1'b1;
    #1 check("R11 early low", {3'b0, early_o}, 4'd0);
    cyc(1);
    check("R11 no valid", {3'b0, valid_o}, 4'd0);
    check("R11 code kept", digit_o, last_code);
    pwr_dn = 1'b0; cyc(2);
    check("R11 recount", {3'b0, valid_o}, 4'd0);
    cyc(1); check("R11 rise after", {3'b0, valid_o}, 4'd1);
    check("R11 new code", digit_o, 4'd10);
    pwr_dn = 1'b1; cyc(1);
    check("R11 drop valid", {3'b0, valid_o}, 4'd0);
    check("R11 code kept 2", digit_o, 4'd10);
    pwr_dn = 1'b0; tone_det = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    t_reset();
    t_all_keys();
    t_on_glitch();
    t_inhibit();
    t_hold_and_oe();
    t_sample();
    t_pwrdn();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule